// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 12-bit successive-approximation converter. A host starts a conversion by pulling its active-low select and read strobes low together. The block then presents a trial code to an external DAC and reads back a one-bit comparator verdict. It settles one result bit per clock, starting at the most significant bit. When the last bit is settled it copies the result into an output latch, and that latch is readable on a parallel bus.

The strobes arrive with no fixed phase to the conversion clock. They pass through a two-flop synchronizer and an edge detector, and only a fresh request seen while the sequencer is idle starts a conversion. While a conversion runs, the active-low busy flag stays low. The old result stays in the latch until the new one replaces it. A host can therefore hold the strobes low for the whole conversion, or pulse them briefly and read the fresh code later with a second access.

The sequencer has three states. In IDLE it waits for a request; the IDLE to ARM transition presets the trial code to half scale and drops busy. ARM is a single settling cycle; ARM to DECIDE loads the bit index with the MSB position. In DECIDE each clock settles one bit; DECIDE stays in DECIDE while the index is above zero, and DECIDE to IDLE happens on the LSB decision, which raises busy and loads the latch.

Top module: `sar_conv_ctrl`

## Requirements
- R1: An active-high synchronous reset drives busy_n high, trial_code to 0, the output latch (rd_data) to 0 and the sequencer to IDLE.
- R2: A conversion starts only when sel_n and rd_n are both low. With both low from some clock onward, busy_n is low after the third rising edge. Either strobe low alone starts nothing.
- R3: On the edge where busy_n falls, trial_code becomes half scale (12'h800: bit 11 set, all others clear).
- R4: The MSB is decided on the second rising edge after the start edge. Each decision edge handles bit k: bit k is kept (1) when cmp_hi is 1 and cleared otherwise, and bit k-1 is set to 1 for the next trial. Bits run from 11 down to 0.
- R5: busy_n stays low for exactly 13 clock periods and rises on the edge that decides bit 0.
- R6: rd_data is loaded only on the edge where busy_n rises. Until then it keeps the previous result.
- R7: While a conversion runs, strobe activity neither restarts nor lengthens it. Strobes that stay low after the conversion ends start no new conversion.
- R8: rd_data_oe is 1 exactly while sel_n and rd_n are both low, and 0 otherwise. Bit 11 of rd_data is the MSB.
- R9: The result is straight binary. With a comparator that reports 1 when the input code is at or above trial_code, the result equals the input code, including 0 and 12'hFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; every decision is taken on its rising edge |
| rst | input | 1 | Active-high synchronous reset |
| sel_n | input | 1 | Active-low select strobe, asynchronous to clk |
| rd_n | input | 1 | Active-low read strobe, asynchronous to clk |
| cmp_hi | input | 1 | Comparator verdict: 1 when the input is at or above the trial level |
| trial_code | output | 12 | Registered trial code driven to the external DAC |
| busy_n | output | 1 | Low while a conversion is in progress |
| rd_data | output | 12 | Output latch contents for the parallel bus |
| rd_data_oe | output | 1 | Drive enable for the parallel bus; 0 means high impedance |

## Verification
A wrong sequencer state shows at the ports within one clock. A stray transition out of ARM or DECIDE moves the busy_n edge away from cycle 3 or 16 after the strobes fall. A wrong bit index leaves a wrong pattern on trial_code as early as the MSB decision on cycle 5. A latch that loads at the wrong time shows a changed rd_data before busy_n rises. An edge detector that misses a held request shows as a second busy_n fall after the first conversion ends.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_ARM,
        S_DECIDE
    } seq_state_e;
endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    output logic start_pulse
);
    logic [STAGES-1:0] chain_q;
    logic              seen_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= req_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= chain_q[STAGES-1];
    end

    assign start_pulse = chain_q[STAGES-1] & ~seen_q;
endmodule

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_pkg::*;
#(
    parameter int WIDTH = 12,
    localparam int IDX_W = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_pulse,
    output logic             preset,
    output logic             decide_en,
    output logic [IDX_W-1:0] bit_idx,
    output logic             busy_n
);
    seq_state_e       st_q, st_d;
    logic [IDX_W-1:0] idx_d;
    logic             busy_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            bit_idx <= '0;
            busy_n  <= 1'b1;
        end else begin
            st_q    <= st_d;
            bit_idx <= idx_d;
            busy_n  <= busy_d;
        end
    end

    always_comb begin
        st_d      = st_q;
        idx_d     = bit_idx;
        busy_d    = busy_n;
        preset    = 1'b0;
        decide_en = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (start_pulse) begin
                    preset = 1'b1;
                    busy_d = 1'b0;
                    st_d   = S_ARM;
                end
            end
            S_ARM: begin
                idx_d = IDX_W'(WIDTH - 1);
                st_d  = S_DECIDE;
            end
            S_DECIDE: begin
                decide_en = 1'b1;
                if (bit_idx == '0) begin
                    busy_d = 1'b1;
                    st_d   = S_IDLE;
                end else begin
                    idx_d = bit_idx - 1'b1;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    // R2
    start_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (start_pulse && st_q == S_IDLE) |=> !busy_n);

    // R5
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_n) |-> $past(st_q == S_DECIDE && bit_idx == '0));
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath #(
    parameter int WIDTH = 12,
    localparam int IDX_W = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             preset,
    input  logic             decide_en,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] trial_q,
    output logic [WIDTH-1:0] result_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            trial_q  <= '0;
            result_q <= '0;
        end else if (preset) begin
            trial_q <= {1'b1, {(WIDTH-1){1'b0}}};
        end else if (decide_en) begin
            for (int i = 0; i < WIDTH; i++) begin
                if (IDX_W'(i) == bit_idx)
                    trial_q[i] <= cmp_hi;
                else if (IDX_W'(i + 1) == bit_idx)
                    trial_q[i] <= 1'b1;
            end
            if (bit_idx == '0)
                result_q <= {trial_q[WIDTH-1:1], cmp_hi};
        end
    end

    // R4
    trial_step_chk: assert property (@(posedge clk) disable iff (rst)
        decide_en |=> $countones(trial_q ^ $past(trial_q)) <= 2);
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
    parameter int WIDTH       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_n,
    input  logic             rd_n,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] trial_code,
    output logic             busy_n,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_data_oe
);
    localparam int IDX_W = $clog2(WIDTH + 1);

    logic             access;
    logic             start_pulse;
    logic             preset;
    logic             decide_en;
    logic [IDX_W-1:0] bit_idx;

    assign access     = ~sel_n & ~rd_n;
    assign rd_data_oe = access;

    sar_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .req_async   (access),
        .start_pulse (start_pulse)
    );

    sar_fsm #(.WIDTH(WIDTH)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_pulse (start_pulse),
        .preset      (preset),
        .decide_en   (decide_en),
        .bit_idx     (bit_idx),
        .busy_n      (busy_n)
    );

    sar_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .preset    (preset),
        .decide_en (decide_en),
        .bit_idx   (bit_idx),
        .cmp_hi    (cmp_hi),
        .trial_q   (trial_code),
        .result_q  (rd_data)
    );

    // R3
    half_scale_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_n) |-> trial_code == {1'b1, {(WIDTH-1){1'b0}}});

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(busy_n) |-> $stable(rd_data));
endmodule

// File: tb/tb_sar_conv_ctrl.sv
`timescale 1ns/1ps
module tb_sar_conv_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        cmp_hi;
    logic [11:0] trial_code;
    logic        busy_n;
    logic [11:0] rd_data;
    logic        rd_data_oe;
    logic [11:0] vin = 12'h000;
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;

    always #2.5 clk = ~clk;

    // comparator model: at or above the trial level
    assign cmp_hi = (vin >= trial_code);

    sar_conv_ctrl dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .rd_n(rd_n), .cmp_hi(cmp_hi),
        .trial_code(trial_code), .busy_n(busy_n), .rd_data(rd_data),
        .rd_data_oe(rd_data_oe)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_err = n_err + 1;
            n_chk = n_chk + 1;
            $display("FAIL watchdog: act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_err = n_err + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        chk("R1 busy_n", busy_n, 1);
        chk("R1 trial", trial_code, 0);
        chk("R1 latch", rd_data, 0);
        rst = 1'b0;
        step();
        chk("R1 idle after release", busy_n, 1);
    endtask

    // slow-memory style: strobes held low through the conversion
    task automatic t_conv(input logic [11:0] v, input logic [11:0] prev);
        vin = v;
        sel_n = 1'b0; rd_n = 1'b0;
        #0.1;
        chk("R8 oe on", rd_data_oe, 1);
        chk("R8 old data", rd_data, prev);
        for (int k = 1; k <= 17; k++) begin
            step();
            if (k == 2) chk("R2 not yet busy", busy_n, 1);
            if (k == 3) begin
                chk("R2 busy falls", busy_n, 0);
                chk("R3 half scale", trial_code, 12'h800);
            end
            if (k == 4) chk("R4 no decision in arm", trial_code, 12'h800);
            if (k == 5) chk("R4 msb decision", trial_code, {v[11], 1'b1, 10'h000});
            if (k == 6) chk("R4 second decision", trial_code, {v[11:10], 1'b1, 9'h000});
            if (k == 15) begin
                chk("R5 still busy", busy_n, 0);
                chk("R6 previous kept", rd_data, prev);
            end
            if (k == 16) begin
                chk("R5 busy ends", busy_n, 1);
                chk("R9 result", rd_data, v);
            end
            if (k == 17) chk("R7 no restart while held", busy_n, 1);
        end
        for (int k = 0; k < 6; k++) begin
            step();
            if (busy_n !== 1'b1) chk("R7 held strobes restart", busy_n, 1);
        end
        sel_n = 1'b1; rd_n = 1'b1;
        step();
        chk("R8 oe off", rd_data_oe, 0);
    endtask

    task automatic t_single_strobe();
        sel_n = 1'b0; rd_n = 1'b1;
        for (int k = 0; k < 6; k++) step();
        chk("R2 sel alone", busy_n, 1);
        chk("R8 oe sel alone", rd_data_oe, 0);
        sel_n = 1'b1; rd_n = 1'b0;
        for (int k = 0; k < 6; k++) step();
        chk("R2 rd alone", busy_n, 1);
        chk("R8 oe rd alone", rd_data_oe, 0);
        rd_n = 1'b1;
        step();
    endtask

    // short pulse start, strobe toggling mid-conversion, later read
    task automatic t_restart(input logic [11:0] v, input logic [11:0] prev);
        int rise_k;
        vin = v;
        rise_k = 0;
        sel_n = 1'b0; rd_n = 1'b0;
        step(); step(); step();
        sel_n = 1'b1; rd_n = 1'b1;
        for (int k = 4; k <= 30; k++) begin
            if (k == 7) begin sel_n = 1'b0; rd_n = 1'b0; end
            if (k == 10) begin sel_n = 1'b1; rd_n = 1'b1; end
            step();
            if (k <= 15 && busy_n !== 1'b0) chk("R7 busy held", busy_n, 0);
            if (busy_n === 1'b1 && rise_k == 0) rise_k = k;
        end
        chk("R7 end not moved", rise_k, 16);
        chk("R7 no second run", busy_n, 1);
        chk("R6 result", rd_data, v);
        sel_n = 1'b0; rd_n = 1'b0;
        #0.1;
        chk("R8 read back", rd_data_oe ? rd_data : 12'hxxx, v);
        chk("R6 prev differs", (prev != v), 1);
        sel_n = 1'b1; rd_n = 1'b1;
        for (int k = 0; k < 20; k++) step();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_conv(12'hA5C, 12'h000);
        t_conv(12'h000, 12'hA5C);
        t_conv(12'hFFF, 12'h000);
        t_conv(12'h801, 12'hFFF);
        t_single_strobe();
        t_restart(12'h3C7, 12'h801);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule